// File: doc/BRIEF.md
# Nine-Port Parallel I/O Expander

This block hangs off a narrow processor bus and gives it nine 8-bit parallel ports. The host reaches it through a 4-bit register address, an 8-bit write bus, an 8-bit read bus and a chip select with two strobes. A bus-mode pin picks the meaning of the strobes. With the pin low, separate active-low read and write strobes are used. With the pin high, one line selects read or write and the other is an active-low enable.

Every port has an output latch, a per-bit direction mask and an output-enable vector for external tri-state buffers. Direction comes from one of two sources. In software mode the host writes three grouping registers, and some ports are split into independently steered nibbles. In strap mode a 3-bit strap sampled during reset fixes how many ports drive. One port is bit-wise programmable in both modes.

All register access is synchronous to `clk`. Reset is synchronous and active low. Read data is combinational while a read cycle is decoded. Ports are numbered 1 to 9, and port n occupies bits [8(n-1)+7 : 8(n-1)] of the flat pin vectors.

Top module: `pio9_expander`

## Requirements
- R1: After reset every output latch is 0x00. With strap value 0 (software mode), every direction bit is 1 (input), so all `pin_oe` bits are 0.
- R2: A write to address 0 through 8 stores the write data in the latch of port 1 through 9. The stored value appears on that port's `pin_out` after the clock edge.
- R3: A direction bit of 1 means input and 0 means output, and `pin_oe` is the inverse of the direction mask. A write to address 9 sets the direction of each bit of port 8, in both modes.
- R4: In software mode, a write to address 10 sets the direction of three ports. Data bit 4 sets all of port 1. Bit 3 sets the upper nibble of port 2 and bit 0 sets its lower nibble. Bit 1 sets all of port 3. Address 11 uses the same bits for ports 4, 5 and 6. At address 12, bit 4 sets port 7 and bit 1 sets port 9.
- R5: A non-zero strap s at reset selects strap mode. In strap mode port 1 is input and port 9 is output. Port k, for k from 2 to 7, is output when s < k and input otherwise. Port 8 starts as input.
- R6: In strap mode, writes to addresses 10, 11 and 12 change no direction.
- R7: A read of address 0 through 8 returns the latch on bits set to output and the live `pin_in` value on bits set to input.
- R8: A latch can be written while its bits are inputs. The stored value is driven as soon as those bits are switched to output.
- R9: Reads of addresses 9 to 15 return 0xFF. Writes to addresses 13 to 15 change nothing. `rdata` is 0x00 in any cycle without a decoded read.
- R10: With `bus_mode` = 0, a read needs `cs_n`=0, `rd_n`=0 and `wr_n`=1, and a write needs `cs_n`=0, `wr_n`=0 and `rd_n`=1. Both strobes low is no access. With `bus_mode` = 1, `cs_n`=0 and `wr_n`=0 start an access: `rd_n`=1 reads and `rd_n`=0 writes.
- R11: The strap is sampled only while reset is held. Later strap changes do not alter the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low; strap is sampled while low |
| bus_mode | input | 1 | 0: separate read/write strobes; 1: R/W select plus enable |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe (mode 0) or R/W select (mode 1) |
| wr_n | input | 1 | Write strobe (mode 0) or access enable (mode 1), active low |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during a decoded read |
| strap | input | 3 | Direction strap; 0 selects software mode |
| pin_in | input | 72 | Live pin levels, port 1 in the low byte |
| pin_out | output | 72 | Latched output values, port 1 in the low byte |
| pin_oe | output | 72 | Per-bit drive enable (1 = drive), port 1 in the low byte |

## Verification
The bench targets the split nibbles of ports 2 and 5. A design that tied the two nibbles together would drive the wrong half. It also targets the read merge on a half-output port, where a design that returned only the latch or only the pins would read a wrong mix. It checks latches written while their bits are inputs and later turned to outputs, where a design that cleared the latch on a direction change would drive zeros. It also checks grouping-register writes and a late strap change in strap mode, where a leaky design would move port directions. Finally it checks both-strobes-low and enable-high cycles in each bus mode, where a loose decoder would store data.

// File: rtl/pio9_pkg.sv
package pio9_pkg;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 9;
  localparam int ADDR_W    = 4;
  localparam int STRAP_W   = 3;
  localparam int HALF_W    = PORT_W / 2;
  localparam int FLAT_W    = NUM_PORTS * PORT_W;

  // register addresses (decoded by the host software)
  localparam int A_MASK8   = 9;
  localparam int A_GRP_A   = 10;
  localparam int A_GRP_B   = 11;
  localparam int A_GRP_C   = 12;

  // bit positions inside the grouping registers
  localparam int GB_WIDE   = 4;
  localparam int GB_HIGH   = 3;
  localparam int GB_ALT    = 1;
  localparam int GB_LOW    = 0;

  // port indices with fixed roles (zero based)
  localparam int IX_FIRST  = 0;
  localparam int IX_BITWISE = 7;
  localparam int IX_LAST   = 8;

  typedef logic [PORT_W-1:0] pbyte_t;
  typedef logic [NUM_PORTS-1:0][PORT_W-1:0] pvec_t;

  // direction a port takes on reset for a given strap value
  function automatic pbyte_t reset_dir(input logic [STRAP_W-1:0] s, input int ix);
    pbyte_t d;
    if (s == '0)              d = '1;
    else if (ix == IX_FIRST)  d = '1;
    else if (ix == IX_LAST)   d = '0;
    else if (ix == IX_BITWISE) d = '1;
    else                      d = (int'(s) < ix + 1) ? '0 : '1;
    return d;
  endfunction
endpackage

// File: rtl/pio9_bus_decode.sv
module pio9_bus_decode (
  input  logic bus_mode,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_en,
  output logic wr_en
);
  logic sel_m1;

  always_comb begin
    sel_m1 = !cs_n && !wr_n;
    if (bus_mode) begin
      rd_en = sel_m1 && rd_n;
      wr_en = sel_m1 && !rd_n;
    end else begin
      rd_en = !cs_n && !rd_n && wr_n;
      wr_en = !cs_n && !wr_n && rd_n;
    end
  end
endmodule

// File: rtl/pio9_dir_ctrl.sv
module pio9_dir_ctrl
  import pio9_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  pbyte_t             wdata,
  output pvec_t              dir
);
  logic  hard_q;
  pvec_t dir_q;
  logic  grp_wr;
  int    grp_base;

  assign dir = dir_q;

  always_comb begin
    grp_wr   = wr_en && !hard_q &&
               (addr == ADDR_W'(A_GRP_A) || addr == ADDR_W'(A_GRP_B));
    grp_base = (addr == ADDR_W'(A_GRP_B)) ? 3 : 0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hard_q <= (strap != '0);
      for (int i = 0; i < NUM_PORTS; i++) dir_q[i] <= reset_dir(strap, i);
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_MASK8)) begin
        dir_q[IX_BITWISE] <= wdata;
      end
      if (grp_wr) begin
        dir_q[grp_base]     <= {PORT_W{wdata[GB_WIDE]}};
        dir_q[grp_base + 1] <= {{HALF_W{wdata[GB_HIGH]}}, {HALF_W{wdata[GB_LOW]}}};
        dir_q[grp_base + 2] <= {PORT_W{wdata[GB_ALT]}};
      end
      if (!hard_q && addr == ADDR_W'(A_GRP_C)) begin
        dir_q[6]       <= {PORT_W{wdata[GB_WIDE]}};
        dir_q[IX_LAST] <= {PORT_W{wdata[GB_ALT]}};
      end
    end
  end

  AST_HARD_FIRST_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |-> dir_q[IX_FIRST] == '1); // R5
  AST_HARD_LAST_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |-> dir_q[IX_LAST] == '0); // R5
  AST_HARD_GROUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_q && wr_en && addr >= ADDR_W'(A_GRP_A) && addr <= ADDR_W'(A_GRP_C))
    |=> ($stable(dir_q[0]) && $stable(dir_q[1]) && $stable(dir_q[2]) &&
         $stable(dir_q[3]) && $stable(dir_q[4]) && $stable(dir_q[5]) &&
         $stable(dir_q[6]) && $stable(dir_q[8]))); // R6
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(hard_q)); // R11
endmodule

// File: rtl/pio9_port_cell.sv
module pio9_port_cell
  import pio9_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_sel,
  input  pbyte_t wdata,
  input  pbyte_t dir,
  input  pbyte_t pin_in,
  output pbyte_t pin_out,
  output pbyte_t pin_oe,
  output pbyte_t rd_val
);
  pbyte_t latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      latch_q <= '0;
    else if (wr_sel) latch_q <= wdata;
  end

  assign pin_out = latch_q;
  assign pin_oe  = ~dir;
  assign rd_val  = (latch_q & ~dir) | (pin_in & dir);

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(latch_q)); // R8
endmodule

// File: rtl/pio9_expander.sv
module pio9_expander
  import pio9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_mode,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [2:0]        strap,
  input  logic [71:0]       pin_in,
  output logic [71:0]       pin_out,
  output logic [71:0]       pin_oe
);
  logic  rd_en, wr_en;
  pvec_t dir;
  pvec_t in_v, out_v, oe_v, rd_v;

  pio9_bus_decode u_dec (
    .bus_mode (bus_mode),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en)
  );

  pio9_dir_ctrl u_dir (
    .clk   (clk),
    .rst_n (rst_n),
    .strap (strap),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .dir   (dir)
  );

  assign in_v = pin_in;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pio9_port_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (wr_en && addr == ADDR_W'(p)),
      .wdata   (wdata),
      .dir     (dir[p]),
      .pin_in  (in_v[p]),
      .pin_out (out_v[p]),
      .pin_oe  (oe_v[p]),
      .rd_val  (rd_v[p])
    );
  end

  assign pin_out = out_v;
  assign pin_oe  = oe_v;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      rdata = '1;
      for (int i = 0; i < NUM_PORTS; i++)
        if (addr == ADDR_W'(i)) rdata = rd_v[i];
    end
  end

  AST_MASK8_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(A_MASK8)) |=> pin_oe[IX_BITWISE*PORT_W +: PORT_W] == ~$past(wdata)); // R3
  AST_BOTH_STROBES_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_mode && !cs_n && !rd_n && !wr_n) |=> $stable(pin_out)); // R10
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n) |-> rdata == 8'h00); // R9
endmodule

// File: tb/pio9_expander_tb_top.sv
module pio9_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_mode = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  strap = '0;
  logic [71:0] pin_in = '0;
  logic [71:0] pin_out, pin_oe;

  int compared = 0;
  int mismatched = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pio9_expander dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .wdata(wdata), .rdata(rdata), .strap(strap),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // behavioural reference model
  logic       m_hard;
  logic [7:0] m_dir [1:9];
  logic [7:0] m_lat [1:9];

  function automatic bit m_write();
    if (cs_n) return 0;
    if (bus_mode) return !wr_n && !rd_n;
    return !wr_n && rd_n;
  endfunction

  function automatic bit m_read();
    if (cs_n) return 0;
    if (bus_mode) return !wr_n && rd_n;
    return !rd_n && wr_n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hard = (strap != 0);
      for (int p = 1; p <= 9; p++) begin
        m_lat[p] = 8'h00;
        if (!m_hard || p == 1 || p == 8) m_dir[p] = 8'hFF;
        else if (p == 9) m_dir[p] = 8'h00;
        else m_dir[p] = (int'(strap) < p) ? 8'h00 : 8'hFF;
      end
    end else if (m_write()) begin
      if (addr <= 8) m_lat[addr + 1] = wdata;
      else if (addr == 9) m_dir[8] = wdata;
      else if (!m_hard && addr == 12) begin
        m_dir[7] = wdata[4] ? 8'hFF : 8'h00;
        m_dir[9] = wdata[1] ? 8'hFF : 8'h00;
      end else if (!m_hard && (addr == 10 || addr == 11)) begin
        int b;
        b = (addr == 10) ? 1 : 4;
        m_dir[b]     = wdata[4] ? 8'hFF : 8'h00;
        m_dir[b + 1] = {wdata[3] ? 4'hF : 4'h0, wdata[0] ? 4'hF : 4'h0};
        m_dir[b + 2] = wdata[1] ? 8'hFF : 8'h00;
      end
    end
    started = 1;
  end

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      logic [71:0] e_out, e_oe;
      logic [7:0]  e_rd;
      for (int p = 1; p <= 9; p++) begin
        e_out[8*(p-1) +: 8] = m_lat[p];
        e_oe[8*(p-1) +: 8]  = ~m_dir[p];
      end
      e_rd = 8'h00;
      if (m_read()) begin
        if (addr <= 8)
          e_rd = (m_lat[addr+1] & ~m_dir[addr+1]) | (pin_in[8*addr +: 8] & m_dir[addr+1]);
        else e_rd = 8'hFF;
      end
      chk("R2 pin_out per cycle", pin_out, e_out);
      chk("R3 pin_oe per cycle", pin_oe, e_oe);
      chk("R7 rdata per cycle", {64'h0, rdata}, {64'h0, e_rd});
    end
  end

  task automatic idle();
    cs_n = 1; rd_n = 1; wr_n = 1;
  endtask

  task automatic do_reset(input logic [2:0] s);
    rst_n = 0; strap = s;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    cs_n = 0; addr = a; wdata = d;
    if (bus_mode) begin rd_n = 0; wr_n = 0; end
    else begin rd_n = 1; wr_n = 0; end
    @(posedge clk); #1 idle();
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    cs_n = 0; addr = a;
    if (bus_mode) begin rd_n = 1; wr_n = 0; end
    else begin rd_n = 0; wr_n = 1; end
    #9 chk(tag, {64'h0, rdata}, {64'h0, exp});
    @(posedge clk); #1 idle();
  endtask

  function automatic logic [7:0] oe_of(input int p);
    return pin_oe[8*(p-1) +: 8];
  endfunction

  function automatic logic [7:0] out_of(input int p);
    return pin_out[8*(p-1) +: 8];
  endfunction

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [71:0] save_oe, save_out;
    pin_in[15:8]  = 8'hC3;
    pin_in[31:24] = 8'h3C;
    @(posedge clk); #1;
    do_reset(3'd0);
    chk("R1 soft reset oe", pin_oe, 72'h0);
    chk("R1 reset latches", pin_out, 72'h0);

    bus_wr(4'd3, 8'hA5);
    chk("R8 latch kept while input oe", {64'h0, oe_of(4)}, 72'h00);
    chk("R2 latch on pin_out", {64'h0, out_of(4)}, 72'hA5);
    bus_rd(4'd3, 8'h3C, "R8 input port reads pins");

    bus_wr(4'd11, 8'h0B);
    chk("R4 grp B bit4 port4", {64'h0, oe_of(4)}, 72'hFF);
    chk("R4 grp B port5", {64'h0, oe_of(5)}, 72'h00);
    bus_rd(4'd3, 8'hA5, "R8 latch driven after switch");

    bus_wr(4'd1, 8'h5A);
    bus_wr(4'd10, 8'h13);
    chk("R4 port2 upper nibble out", {64'h0, oe_of(2)}, 72'hF0);
    chk("R4 port1 input", {64'h0, oe_of(1)}, 72'h00);
    bus_rd(4'd1, 8'h53, "R7 merged read");

    bus_wr(4'd10, 8'h09);
    chk("R4 grp A 09", {48'h0, oe_of(3), oe_of(2), oe_of(1)}, 72'hFF00FF);

    bus_wr(4'd9, 8'h0F);
    chk("R3 port8 bitwise", {64'h0, oe_of(8)}, 72'hF0);

    bus_wr(4'd12, 8'h02);
    chk("R4 grp C 02", {56'h0, oe_of(9), oe_of(7)}, 72'h00FF);
    bus_wr(4'd12, 8'h10);
    chk("R4 grp C 10", {56'h0, oe_of(9), oe_of(7)}, 72'hFF00);

    bus_rd(4'd9, 8'hFF, "R9 read addr 9");
    bus_rd(4'd15, 8'hFF, "R9 read addr 15");
    save_oe = pin_oe; save_out = pin_out;
    bus_wr(4'd13, 8'h00);
    bus_wr(4'd15, 8'hFF);
    chk("R9 write 13-15 oe", pin_oe, save_oe);
    chk("R9 write 13-15 out", pin_out, save_out);
    chk("R9 idle rdata", {64'h0, rdata}, 72'h0);

    cs_n = 0; rd_n = 0; wr_n = 0; addr = 4'd3; wdata = 8'h00;
    @(posedge clk); #1 idle();
    chk("R10 both strobes no write", {64'h0, out_of(4)}, 72'hA5);

    bus_mode = 1;
    bus_wr(4'd3, 8'h3E);
    chk("R10 mode1 write", {64'h0, out_of(4)}, 72'h3E);
    bus_rd(4'd3, 8'h3E, "R10 mode1 read");
    cs_n = 0; rd_n = 0; wr_n = 1; addr = 4'd3; wdata = 8'h00;
    @(posedge clk); #1 idle();
    chk("R10 mode1 enable high no write", {64'h0, out_of(4)}, 72'h3E);
    bus_mode = 0;

    do_reset(3'd3);
    chk("R5 strap 3 oe", pin_oe, 72'hFF_00_FF_FF_FF_FF_00_00_00);
    chk("R1 strap reset latches", pin_out, 72'h0);
    bus_wr(4'd10, 8'h00);
    bus_wr(4'd11, 8'hFF);
    bus_wr(4'd12, 8'h1B);
    chk("R6 group writes ignored", pin_oe, 72'hFF_00_FF_FF_FF_FF_00_00_00);
    bus_wr(4'd9, 8'h00);
    chk("R3 port8 in strap mode", {64'h0, oe_of(8)}, 72'hFF);
    strap = 3'd0;
    bus_wr(4'd11, 8'h1B);
    chk("R11 late strap change", {64'h0, oe_of(4)}, 72'hFF);

    do_reset(3'd7);
    chk("R5 strap 7 oe", pin_oe, 72'hFF_00_00_00_00_00_00_00_00);
    do_reset(3'd1);
    chk("R5 strap 1 oe", pin_oe, 72'hFF_00_FF_FF_FF_FF_FF_FF_00);

    do_reset(3'd0);
    for (int n = 0; n < 4000; n++) begin
      rst_n    = ($urandom % 250) != 0;
      strap    = 3'($urandom);
      bus_mode = 1'($urandom);
      cs_n     = ($urandom % 4) == 0;
      rd_n     = 1'($urandom);
      wr_n     = 1'($urandom);
      addr     = 4'($urandom);
      wdata    = 8'($urandom);
      pin_in   = {8'($urandom), 32'($urandom), 32'($urandom)};
      @(posedge clk); #1;
    end
    idle(); rst_n = 1;
    @(posedge clk); #1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule